// File: doc/BRIEF.md
# Palette Colour Table with Sequential Component Port

This block holds the colour look-up table of a pseudocolour display controller: 256 normal entries, selected by an 8-bit pixel value, and 4 overlay entries used by a hardware cursor. Each entry stores an 8-bit red, an 8-bit green and an 8-bit blue value.

Software reaches the table through a 32-bit word port. It first loads an index. It then writes or reads the three components of that entry one after another. An internal phase counter steps through red, green and blue. After the third component the index advances on its own, so a whole palette can be streamed without reloading the index. Overlay entries share the same index register: only its low two bits choose the overlay entry.

The pixel pipeline uses a separate combinational lookup port. It takes a 9-bit entry number and returns the 24-bit colour.

Top module: `clut_dac`

## Requirements
- R1: A write to byte offset 0 takes the new index from data bits 31:24 and sets the component phase back to red. This holds even in the middle of a component sequence.
- R2: A write to byte offset 4 stores data bits 31:24 into one component of normal entry [index]. Phase 0 selects red, phase 1 green and phase 2 blue. The phase then moves to the next component. Data bits 23:0 are ignored.
- R3: A write to byte offset 12 works like R2 but targets overlay entry 256 + index[1:0]. It steps the phase and the index in the same way.
- R4: An access made in the blue phase returns the phase to red and increments the index modulo 256, so 255 wraps to 0. This applies to writes at offsets 4 and 12 and to every read.
- R5: A read returns the phase-selected component of normal entry [index] in bits 31:24 and zeros in bits 23:0. The byte offset does not matter for a read, and a read never returns an overlay entry. The read advances the phase and index as in R2 and R4.
- R6: After reset, every component of every entry is 0 except entries 255, 256 and 258, which are 255 in all three components. The index and the phase are 0.
- R7: A write to any byte offset other than 0, 4 or 12 changes no entry, no index and no phase.
- R8: The lookup port returns {red, green, blue} in bits 23:16, 15:8 and 7:0 for entries 0 to 259. It returns 0 for entry numbers 260 to 511.
- R9: A component write shows on the lookup port from the cycle after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_req | input | 1 | Host access in this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Byte offset of the word access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid while a read is presented |
| lut_index | input | 9 | Entry number for the pixel lookup |
| lut_color | output | 24 | Looked-up colour {R,G,B} |

## Verification
The assertions assume that each host access lasts exactly one cycle. They also assume that host_we is a clean level while host_req is high, and that host_addr is a byte offset within the 16-byte window. The stimulus drives every access for a single clock on the falling edge and drops host_req between groups of accesses. Read data is sampled within that same cycle, before the edge that advances the phase. Lookups are made only while the host port is idle, so no lookup overlaps a table write.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_INDEX,
    OP_LOAD_NORMAL,
    OP_LOAD_OVERLAY,
    OP_READ
  } op_e;

endpackage

// File: rtl/clut_decode.sv
module clut_decode
  import clut_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int OFS_INDEX   = 0,
  parameter int OFS_NORMAL  = 4,
  parameter int OFS_OVERLAY = 12
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op
);

  always_comb begin
    op = OP_NONE;
    if (req) begin
      if (!we) begin
        op = OP_READ;
      end else if (addr == ADDR_W'(OFS_INDEX)) begin
        op = OP_SET_INDEX;
      end else if (addr == ADDR_W'(OFS_NORMAL)) begin
        op = OP_LOAD_NORMAL;
      end else if (addr == ADDR_W'(OFS_OVERLAY)) begin
        op = OP_LOAD_OVERLAY;
      end else begin
        op = OP_NONE;
      end
    end
  end

endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8,
  parameter int NORM_N = 256,
  parameter int OVL_W  = 2,
  parameter int LUT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [COMP_W-1:0] field,
  output logic [IDX_W-1:0]  idx_o,
  output phase_e            phase_o,
  output logic              wr_en,
  output logic [LUT_W-1:0]  wr_entry,
  output logic [2:0]        wr_comp
);

  logic [IDX_W-1:0] idx_q, idx_d;
  phase_e           ph_q, ph_d;
  logic             step_en;
  logic             stepping;

  assign stepping = (op == OP_LOAD_NORMAL) || (op == OP_LOAD_OVERLAY) ||
                    (op == OP_READ);
  assign step_en  = stepping || (op == OP_SET_INDEX);

  always_comb begin
    idx_d = idx_q;
    ph_d  = ph_q;
    if (op == OP_SET_INDEX) begin
      idx_d = field[COMP_W-1 -: IDX_W];
      ph_d  = PH_RED;
    end else if (stepping) begin
      if (ph_q == PH_BLUE) begin
        ph_d  = PH_RED;
        idx_d = idx_q + IDX_W'(1);
      end else begin
        ph_d  = phase_e'(ph_q + 2'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
    end else if (step_en) begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
    end
  end

  always_comb begin
    wr_en    = (op == OP_LOAD_NORMAL) || (op == OP_LOAD_OVERLAY);
    wr_entry = LUT_W'(idx_q);
    if (op == OP_LOAD_OVERLAY) begin
      wr_entry = LUT_W'(NORM_N) + LUT_W'(idx_q[OVL_W-1:0]);
    end
    case (ph_q)
      PH_RED:   wr_comp = 3'b100;
      PH_GREEN: wr_comp = 3'b010;
      PH_BLUE:  wr_comp = 3'b001;
      default:  wr_comp = 3'b000;
    endcase
  end

  assign idx_o   = idx_q;
  assign phase_o = ph_q;

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET_INDEX) |=> (idx_q == $past(field[COMP_W-1 -: IDX_W])) &&
                             (ph_q == PH_RED)); // R1

  AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && ph_q == PH_BLUE) |=> (ph_q == PH_RED) &&
                                      (idx_q == $past(idx_q) + IDX_W'(1))); // R4

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != phase_e'(2'd3)); // R4

endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int COMP_W = 8,
  parameter int NORM_N = 256,
  parameter int TOT_N  = 260,
  parameter int LUT_W  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [LUT_W-1:0]    wr_entry,
  input  logic [2:0]          wr_comp,
  input  logic [COMP_W-1:0]   wr_val,
  input  logic [LUT_W-1:0]    rd_entry,
  output logic [3*COMP_W-1:0] rd_color,
  input  logic [LUT_W-1:0]    lut_index,
  output logic [3*COMP_W-1:0] lut_color
);

  localparam int ENT_W = 3 * COMP_W;

  logic [ENT_W-1:0] ent_q [TOT_N];

  for (genvar e = 0; e < TOT_N; e++) begin : g_ent
    localparam bit WHITE = (e == NORM_N - 1) || (e == NORM_N) || (e == NORM_N + 2);
    localparam logic [ENT_W-1:0] RST_VAL = {ENT_W{WHITE}};

    logic [ENT_W-1:0] cell_q, cell_d;
    logic             hit;

    assign hit = wr_en && (wr_entry == LUT_W'(e));

    always_comb begin
      cell_d = cell_q;
      for (int c = 0; c < 3; c++) begin
        if (wr_comp[2-c]) begin
          cell_d[ENT_W-1-c*COMP_W -: COMP_W] = wr_val;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= RST_VAL;
      end else if (hit) begin
        cell_q <= cell_d;
      end
    end

    assign ent_q[e] = cell_q;
  end

  assign rd_color = (rd_entry < LUT_W'(TOT_N)) ? ent_q[rd_entry] : '0;

  always_comb begin
    lut_color = '0;
    if (lut_index < LUT_W'(TOT_N)) begin
      lut_color = ent_q[lut_index];
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot(wr_comp)); // R2

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_comp[0] && wr_entry < LUT_W'(TOT_N)) |=>
      (ent_q[$past(wr_entry)][COMP_W-1:0] == $past(wr_val))); // R9

  AST_LUT_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_index >= LUT_W'(TOT_N)) |-> (lut_color == '0)); // R8

endmodule

// File: rtl/clut_dac.sv
module clut_dac
  import clut_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int COMP_W       = 8,
  parameter int NORM_ENTRIES = 256,
  parameter int OVL_ENTRIES  = 4,
  parameter int ADDR_W       = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_req,
  input  logic                          host_we,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [DATA_W-1:0]             host_wdata,
  output logic [DATA_W-1:0]             host_rdata,
  input  logic [$clog2(NORM_ENTRIES+OVL_ENTRIES)-1:0] lut_index,
  output logic [3*COMP_W-1:0]           lut_color
);

  localparam int IDX_W = $clog2(NORM_ENTRIES);
  localparam int OVL_W = $clog2(OVL_ENTRIES);
  localparam int TOT_N = NORM_ENTRIES + OVL_ENTRIES;
  localparam int LUT_W = $clog2(TOT_N);

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  op_e                  op;
  logic [COMP_W-1:0]    field;
  logic                 unused_low;
  logic [IDX_W-1:0]     idx;
  phase_e               phase;
  logic                 wr_en;
  logic [LUT_W-1:0]     wr_entry;
  logic [2:0]           wr_comp;
  logic [3*COMP_W-1:0]  rd_color;
  logic [COMP_W-1:0]    rd_comp;

  assign field      = host_wdata[DATA_W-1 -: COMP_W];
  assign unused_low = ^host_wdata[DATA_W-COMP_W-1:0];

  clut_decode #(
    .ADDR_W (ADDR_W)
  ) u_decode (
    .req  (host_req),
    .we   (host_we),
    .addr (host_addr),
    .op   (op)
  );

  clut_seq #(
    .COMP_W (COMP_W),
    .IDX_W  (IDX_W),
    .NORM_N (NORM_ENTRIES),
    .OVL_W  (OVL_W),
    .LUT_W  (LUT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync),
    .op       (op),
    .field    (field),
    .idx_o    (idx),
    .phase_o  (phase),
    .wr_en    (wr_en),
    .wr_entry (wr_entry),
    .wr_comp  (wr_comp)
  );

  clut_store #(
    .COMP_W (COMP_W),
    .NORM_N (NORM_ENTRIES),
    .TOT_N  (TOT_N),
    .LUT_W  (LUT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync),
    .wr_en     (wr_en),
    .wr_entry  (wr_entry),
    .wr_comp   (wr_comp),
    .wr_val    (field),
    .rd_entry  (LUT_W'(idx)),
    .rd_color  (rd_color),
    .lut_index (lut_index),
    .lut_color (lut_color)
  );

  always_comb begin
    case (phase)
      PH_RED:   rd_comp = rd_color[3*COMP_W-1 -: COMP_W];
      PH_GREEN: rd_comp = rd_color[2*COMP_W-1 -: COMP_W];
      PH_BLUE:  rd_comp = rd_color[COMP_W-1:0];
      default:  rd_comp = '0;
    endcase
    host_rdata = '0;
    if (host_req && !host_we) begin
      host_rdata = {rd_comp, {(DATA_W-COMP_W){1'b0}}};
    end
  end

  AST_IGNORE_OFFSET: assert property (@(posedge clk) disable iff (!rst_sync)
    (host_req && host_we && host_addr != ADDR_W'(0) && host_addr != ADDR_W'(4) &&
     host_addr != ADDR_W'(12)) |=> $stable(idx) && $stable(phase)); // R7

  AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_sync)
    (host_req && !host_we) |-> (host_rdata[DATA_W-COMP_W-1:0] == '0)); // R5

endmodule

// File: tb/clut_dac_test.sv
module clut_dac_test;

  logic        clk;
  logic        rst_n;
  logic        host_req;
  logic        host_we;
  logic [3:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [8:0]  lut_index;
  logic [23:0] lut_color;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  clut_dac uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .lut_index  (lut_index),
    .lut_color  (lut_color)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int m_r [260];
  int m_g [260];
  int m_b [260];
  int m_idx;
  int m_ph;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic model_step();
    if (m_ph == 2) begin
      m_ph  = 0;
      m_idx = (m_idx + 1) % 256;
    end else begin
      m_ph = m_ph + 1;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    int ent;
    int v;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    v = int'(d[31:24]);
    if (a == 4'd0) begin
      m_idx = v; m_ph = 0;
    end else if (a == 4'd4 || a == 4'd12) begin
      ent = (a == 4'd4) ? m_idx : 256 + (m_idx % 4);
      if (m_ph == 0) m_r[ent] = v;
      else if (m_ph == 1) m_g[ent] = v;
      else m_b[ent] = v;
      model_step();
    end
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    int v;
    v = (m_ph == 0) ? m_r[m_idx] : (m_ph == 1) ? m_g[m_idx] : m_b[m_idx];
    exp_q.push_back({v[7:0], 24'h0});
    tag_q.push_back(tag);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a; host_wdata = 32'h0;
    model_step();
  endtask

  task automatic lut_chk(input int e, input string tag);
    logic [23:0] exp;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    lut_index = 9'(e);
    exp = (e < 260) ? {m_r[e][7:0], m_g[e][7:0], m_b[e][7:0]} : 24'h0;
    #1;
    total++;
    if (lut_color !== exp) begin
      bad++;
      $display("FAIL %s lookup entry %0d: actual=%06h expected=%06h", tag, e, lut_color, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    #2;
    if (host_req && !host_we) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R5 unexpected read: actual=%08h expected=none", host_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (host_rdata !== e) begin
          bad++;
          $display("FAIL %s read: actual=%08h expected=%08h", t, host_rdata, e);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 260; i++) begin
      m_r[i] = 0; m_g[i] = 0; m_b[i] = 0;
    end
    m_r[255] = 255; m_g[255] = 255; m_b[255] = 255;
    m_r[256] = 255; m_g[256] = 255; m_b[256] = 255;
    m_r[258] = 255; m_g[258] = 255; m_b[258] = 255;
    m_idx = 0; m_ph = 0;
    host_req = 1'b0; host_we = 1'b0; host_addr = 4'h0; host_wdata = 32'h0;
    lut_index = 9'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset contents
    lut_chk(0,   "R6");
    lut_chk(254, "R6");
    lut_chk(255, "R6");
    lut_chk(256, "R6");
    lut_chk(257, "R6");
    lut_chk(258, "R6");
    lut_chk(259, "R6");
    // R6 index and phase start at 0: read entry 0 components, then entry 1
    rd(4'h0, "R6");
    rd(4'h0, "R6");
    rd(4'h0, "R6");
    rd(4'h0, "R4");

    // R1 R2 R9: load entry 5, low data bits are ignored
    wr(4'h0, 32'h05_00_00_00);
    wr(4'h4, 32'hA1_12_34_56);
    wr(4'h4, 32'hB2_FF_FF_FF);
    wr(4'h4, 32'hC3_00_00_01);
    lut_chk(5, "R9");
    lut_chk(6, "R2");
    // R5 read back entry 5, then R4 step on to entry 6
    wr(4'h0, 32'h05_00_00_00);
    rd(4'h4, "R5");
    rd(4'h8, "R5");
    rd(4'hC, "R5");
    rd(4'h0, "R4");

    // R1 index reload mid-sequence resets the phase
    wr(4'h0, 32'h0A_00_00_00);
    wr(4'h4, 32'h11_00_00_00);
    wr(4'h4, 32'h22_00_00_00);
    wr(4'h0, 32'h0A_00_00_00);
    wr(4'h4, 32'h33_00_00_00);
    lut_chk(10, "R1");

    // R7 ignored offsets inside a sequence
    wr(4'h0, 32'h14_00_00_00);
    wr(4'h4, 32'h44_00_00_00);
    wr(4'h8, 32'h99_00_00_00);
    wr(4'h2, 32'h98_00_00_00);
    wr(4'hF, 32'h97_00_00_00);
    wr(4'h4, 32'h55_00_00_00);
    wr(4'h4, 32'h66_00_00_00);
    lut_chk(20, "R7");
    lut_chk(21, "R7");
    rd(4'h0, "R7");

    // R3 overlay: index 7 -> entry 259, then index 8 -> entry 256
    wr(4'h0, 32'h07_00_00_00);
    wr(4'hC, 32'h10_00_00_00);
    wr(4'hC, 32'h20_00_00_00);
    wr(4'hC, 32'h30_00_00_00);
    lut_chk(259, "R3");
    lut_chk(7,   "R3");
    wr(4'hC, 32'h40_00_00_00);
    wr(4'hC, 32'h50_00_00_00);
    wr(4'hC, 32'h60_00_00_00);
    lut_chk(256, "R3");
    lut_chk(8,   "R3");
    // R5 a read at index 7 returns the normal entry, not the overlay
    wr(4'h0, 32'h07_00_00_00);
    rd(4'hC, "R5");

    // R4 index wraps from 255 to 0 on writes
    wr(4'h0, 32'hFF_00_00_00);
    wr(4'h4, 32'h01_00_00_00);
    wr(4'h4, 32'h02_00_00_00);
    wr(4'h4, 32'h03_00_00_00);
    wr(4'h4, 32'h7E_00_00_00);
    lut_chk(255, "R4");
    lut_chk(0,   "R4");

    // R4 R5 index wraps on reads
    wr(4'h0, 32'hFF_00_00_00);
    rd(4'h4, "R5");
    rd(4'h4, "R5");
    rd(4'h4, "R4");
    rd(4'h4, "R4");

    // R8 entries past the table read as zero
    lut_chk(260, "R8");
    lut_chk(300, "R8");
    lut_chk(511, "R8");

    @(negedge clk);
    host_req = 1'b0;
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R5 pending reads: actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule